// File: doc/BRIEF.md
# Configuration Test Access Port with Command Decoder

This block is a four-wire serial test port for a device configuration engine. It holds the standard sixteen-state test access controller, an 8-bit instruction register, a 32-bit identification register, a 32-bit configuration status register and a one-bit bypass register. Instructions shifted in through the instruction path are decoded into one-cycle command strobes that tell the configuration engine to enable or disable configuration, erase, finish an erase, initialise its address counter, take data, reprogram or do nothing. The engine drives the raw error and completion flags that are read back through the status instruction.

All logic runs on the test clock. The active-low reset acts as an asynchronous test reset. The serial output is launched on the falling clock edge, and a separate enable output says when the pin is driven. When that enable is low the pad is released to high impedance.

Top module: `cfg_tap_top`

## Requirements
- R1: While reset is asserted, and right after it is released, `tdo_oe` is low, `cmd_strobe` is all zero, and the active instruction is the identification read (0x11).
- R2: Five consecutive test clocks with `tms` high, from any state, place the controller in Test-Logic-Reset. This reloads the identification instruction and clears the configuration-enable condition.
- R3: With instruction 0x11 active, a 32-clock data scan shifts out the `IDCODE` parameter on `tdo`, least significant bit first. The bit shifted in together with `tms` high is the last one and takes the controller to Exit1.
- R4: With instruction 0x41 active, a data scan returns the status word captured in Capture-DR: bit 0 is `eng_crc_err`, bit 1 is the sticky bad-instruction flag, bit 2 is `eng_id_fail`, bit 3 is `eng_timeout`, bit 13 is `eng_done`, and every other bit is 0.
- R5: When Update-IR is left, a recognised command raises its bit of `cmd_strobe` for exactly one test clock. The bit positions are: 0 enable (0x15), 1 disable (0x3A), 2 no-op (0x02), 3 erase (0x05), 4 erase done (0x09), 5 address init (0x12), 6 data transfer (0x17), 7 reprogram (0x3C). Instructions 0x11 and 0x41 raise no strobe.
- R6: The erase (bit 3) and data-transfer (bit 6) strobes are held low unless an enable command was decoded after the last disable command and after the last pass through Test-Logic-Reset.
- R7: Any other instruction code selects the bypass register and sets the bad-instruction status bit. The bypass register captures 0 and delays `tdi` by one clock on its way to `tdo`. The flag stays set until reset.
- R8: `tdo_oe` is high only in the half cycles that follow a falling edge in Shift-DR or Shift-IR.
- R9: Capture-IR loads the pattern 0x01 into the instruction shifter, and this pattern is shifted out least significant bit first during Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, launched on falling edge |
| tdo_oe | output | 1 | High when tdo is driven; low means high impedance |
| eng_crc_err | input | 1 | Engine CRC error flag |
| eng_id_fail | input | 1 | Engine identity-check failure flag |
| eng_timeout | input | 1 | Engine timeout flag |
| eng_done | input | 1 | Engine configuration complete |
| cmd_strobe | output | 8 | One-clock command pulses, positions as in R5 |

## Verification
Two functions can fall in the same Update-IR clock. An unrecognised code both selects the bypass register and sets the bad-instruction flag. The bench scans 0x55, shifts a known pattern to confirm the one-bit delay, and then reads the status word to see the flag next to the engine flags. The enable gate is the second case: a gated strobe and the update of the enable condition are decided on the same edge. The bench sends transfer and erase before enable, after disable and after a five-clock reset, and checks that no pulse appears.

// File: rtl/cfg_tap_pkg.sv
`timescale 1ns/1ps
package cfg_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYPASS, SEL_ID, SEL_STATUS} dr_sel_e;

  localparam int IR_W = 8;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

  localparam logic [IR_W-1:0] OP_IDCODE     = 8'h11;
  localparam logic [IR_W-1:0] OP_STATUS     = 8'h41;
  localparam logic [IR_W-1:0] OP_CFG_EN     = 8'h15;
  localparam logic [IR_W-1:0] OP_CFG_DIS    = 8'h3A;
  localparam logic [IR_W-1:0] OP_NOOP       = 8'h02;
  localparam logic [IR_W-1:0] OP_ERASE      = 8'h05;
  localparam logic [IR_W-1:0] OP_ERASE_DONE = 8'h09;
  localparam logic [IR_W-1:0] OP_ADDR_INIT  = 8'h12;
  localparam logic [IR_W-1:0] OP_XFER       = 8'h17;
  localparam logic [IR_W-1:0] OP_REPROG     = 8'h3C;

  localparam int NUM_CMD        = 8;
  localparam int CMD_EN         = 0;
  localparam int CMD_DIS        = 1;
  localparam int CMD_NOOP       = 2;
  localparam int CMD_ERASE      = 3;
  localparam int CMD_ERASE_DONE = 4;
  localparam int CMD_ADDR_INIT  = 5;
  localparam int CMD_XFER       = 6;
  localparam int CMD_REPROG     = 7;

  // opcode of command i lives in slice [i*IR_W +: IR_W]
  localparam logic [NUM_CMD*IR_W-1:0] CMD_TABLE = {
    OP_REPROG, OP_XFER, OP_ADDR_INIT, OP_ERASE_DONE,
    OP_ERASE, OP_NOOP, OP_CFG_DIS, OP_CFG_EN
  };

  localparam int STAT_W        = 32;
  localparam int SB_CRC        = 0;
  localparam int SB_BAD_CMD    = 1;
  localparam int SB_ID_FAIL    = 2;
  localparam int SB_TIMEOUT    = 3;
  localparam int SB_DONE       = 13;

  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    tap_state_e n;
    case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  function automatic logic [NUM_CMD-1:0] cmd_decode(logic [IR_W-1:0] op);
    logic [NUM_CMD-1:0] hit;
    for (int i = 0; i < NUM_CMD; i++)
      hit[i] = (op == CMD_TABLE[i*IR_W +: IR_W]);
    return hit;
  endfunction

  function automatic logic op_known(logic [IR_W-1:0] op);
    return (|cmd_decode(op)) || (op == OP_IDCODE) || (op == OP_STATUS);
  endfunction

  function automatic dr_sel_e dr_select(logic [IR_W-1:0] op);
    if (op == OP_IDCODE) return SEL_ID;
    if (op == OP_STATUS) return SEL_STATUS;
    return SEL_BYPASS;
  endfunction

  function automatic logic [STAT_W-1:0] status_pack(logic crc, logic bad,
                                                    logic idf, logic tmo,
                                                    logic done);
    logic [STAT_W-1:0] w;
    w = '0;
    w[SB_CRC]     = crc;
    w[SB_BAD_CMD] = bad;
    w[SB_ID_FAIL] = idf;
    w[SB_TIMEOUT] = tmo;
    w[SB_DONE]    = done;
    return w;
  endfunction

endpackage

// File: rtl/cfg_tap_fsm.sv
`timescale 1ns/1ps
module cfg_tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

  // independent count of consecutive tms-high clocks, saturating at five
  localparam int RESET_RUN = 5;
  logic [2:0] ones_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                         ones_run <= '0;
    else if (!tms)                      ones_run <= '0;
    else if (ones_run != 3'(RESET_RUN)) ones_run <= ones_run + 3'd1;
  end

  assert_tlr_after_five_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_run == 3'(RESET_RUN)) |-> (state == ST_TLR));

endmodule

// File: rtl/cfg_tap_ir.sv
`timescale 1ns/1ps
module cfg_tap_ir
  import cfg_tap_pkg::*;
(
  input  logic                tck,
  input  logic                rst_n,
  input  tap_state_e          state,
  input  logic                tdi,
  output logic [IR_W-1:0]     ir_q,
  output logic                ir_tdo,
  output logic [NUM_CMD-1:0]  cmd_strobe,
  output logic                bad_cmd
);

  logic [IR_W-1:0]    ir_sh;
  logic               cfg_en_q;
  logic               upd_ir_w;
  logic               unknown_w;
  logic [NUM_CMD-1:0] raw_cmd_w;
  logic [NUM_CMD-1:0] gated_cmd_w;

  assign upd_ir_w  = (state == ST_UPD_IR);
  assign unknown_w = upd_ir_w && !op_known(ir_sh);
  assign raw_cmd_w = cmd_decode(ir_sh);

  always_comb begin
    gated_cmd_w = raw_cmd_w;
    if (!cfg_en_q) begin
      gated_cmd_w[CMD_ERASE] = 1'b0;
      gated_cmd_w[CMD_XFER]  = 1'b0;
    end
  end

  assign ir_tdo = ir_sh[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh      <= '0;
      ir_q       <= OP_IDCODE;
      cmd_strobe <= '0;
      cfg_en_q   <= 1'b0;
      bad_cmd    <= 1'b0;
    end else begin
      cmd_strobe <= '0;
      case (state)
        ST_TLR: begin
          ir_q     <= OP_IDCODE;
          cfg_en_q <= 1'b0;
        end
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: begin
          ir_q       <= ir_sh;
          cmd_strobe <= gated_cmd_w;
          if (raw_cmd_w[CMD_EN])       cfg_en_q <= 1'b1;
          else if (raw_cmd_w[CMD_DIS]) cfg_en_q <= 1'b0;
          if (unknown_w)               bad_cmd  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_strobe_onehot_R5: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  assert_strobe_single_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (|cmd_strobe) |=> (cmd_strobe == '0));

  assert_gate_enable_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (cmd_strobe[CMD_XFER] || cmd_strobe[CMD_ERASE]) |-> $past(cfg_en_q));

  assert_bad_sticky_R7: assert property (@(posedge tck) disable iff (!rst_n)
    unknown_w |=> bad_cmd);

endmodule

// File: rtl/cfg_tap_dr.sv
`timescale 1ns/1ps
module cfg_tap_dr
  import cfg_tap_pkg::*;
#(
  parameter int DR_W = 32
)(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic [IR_W-1:0] ir_q,
  input  logic [DR_W-1:0] id_word,
  input  logic [DR_W-1:0] status_word,
  output logic            dr_tdo
);

  logic [DR_W-1:0] dr_sh;
  logic            byp_q;
  dr_sel_e         sel_w;

  assign sel_w  = dr_select(ir_q);
  assign dr_tdo = (sel_w == SEL_BYPASS) ? byp_q : dr_sh[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      dr_sh <= '0;
      byp_q <= 1'b0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          case (sel_w)
            SEL_ID:     dr_sh <= id_word;
            SEL_STATUS: dr_sh <= status_word;
            default:    byp_q <= 1'b0;
          endcase
        end
        ST_SH_DR: begin
          if (sel_w == SEL_BYPASS) byp_q <= tdi;
          else                     dr_sh <= {tdi, dr_sh[DR_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  assert_capture_id_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && sel_w == SEL_ID) |=> (dr_sh == $past(id_word)));

  assert_bypass_zero_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && sel_w == SEL_BYPASS) |=> !byp_q);

endmodule

// File: rtl/cfg_tap_top.sv
`timescale 1ns/1ps
module cfg_tap_top
  import cfg_tap_pkg::*;
#(
  parameter int          DR_W   = 32,
  parameter logic [31:0] IDCODE = 32'h4C07_A0E3
)(
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic               eng_crc_err,
  input  logic               eng_id_fail,
  input  logic               eng_timeout,
  input  logic               eng_done,
  output logic [NUM_CMD-1:0] cmd_strobe
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_tdo;
  logic            dr_tdo;
  logic            bad_cmd;
  logic [DR_W-1:0] status_word;
  logic [DR_W-1:0] id_word;
  logic            shifting_w;

  assign status_word = DR_W'(status_pack(eng_crc_err, bad_cmd, eng_id_fail,
                                         eng_timeout, eng_done));
  assign id_word     = DR_W'(IDCODE);
  assign shifting_w  = (state == ST_SH_DR) || (state == ST_SH_IR);

  cfg_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  cfg_tap_ir u_ir (
    .tck        (tck),
    .rst_n      (rst_n),
    .state      (state),
    .tdi        (tdi),
    .ir_q       (ir_q),
    .ir_tdo     (ir_tdo),
    .cmd_strobe (cmd_strobe),
    .bad_cmd    (bad_cmd)
  );

  cfg_tap_dr #(.DR_W(DR_W)) u_dr (
    .tck         (tck),
    .rst_n       (rst_n),
    .state       (state),
    .tdi         (tdi),
    .ir_q        (ir_q),
    .id_word     (id_word),
    .status_word (status_word),
    .dr_tdo      (dr_tdo)
  );

  // output stage launched on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting_w;
      tdo    <= (state == ST_SH_IR) ? ir_tdo : dr_tdo;
    end
  end

  assert_oe_only_shift_R8: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> ($past(state) == ST_SH_DR || $past(state) == ST_SH_IR
                || state == ST_SH_DR || state == ST_SH_IR));

  assert_reset_quiet_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |-> (cmd_strobe == '0));

endmodule

// File: tb/sim_cfg_tap_top.sv
`timescale 1ns/1ps
module sim_cfg_tap_top;

  localparam logic [31:0] IDC = 32'h4C07_A0E3;

  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo, tdo_oe;
  logic       crc = 1'b0, idf = 1'b0, tmo = 1'b0, done = 1'b0;
  logic [7:0] stb;

  cfg_tap_top #(.IDCODE(IDC)) u0 (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .eng_crc_err(crc), .eng_id_fail(idf), .eng_timeout(tmo), .eng_done(done),
    .cmd_strobe(stb)
  );

  always #10 tck = ~tck;  // 50 MHz

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct { string req; logic [31:0] exp; } item_t;
  item_t exp_q[$];

  logic       smp_tdo, smp_oe;
  logic [7:0] smp_stb;

  task automatic push_exp(input string req, input logic [31:0] v);
    item_t it;
    it.req = req; it.exp = v;
    exp_q.push_back(it);
  endtask

  // monitor side: pop the oldest expectation and compare
  task automatic observe(input logic [31:0] act);
    item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty actual=%h expected=none", act);
    end else begin
      it = exp_q.pop_front();
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  endtask

  // drive at negedge+1, sample at next negedge+1
  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
    smp_tdo = tdo; smp_oe = tdo_oe; smp_stb = stb;
  endtask

  task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap,
                         output logic [7:0] strobe);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = smp_tdo;
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i]);
      if (i < 7) cap[i+1] = smp_tdo;
    end
    step(1, 0); step(0, 0);
    strobe = smp_stb;
  endtask

  logic oe_in_shift, oe_in_exit;

  task automatic dr_scan(input int n, input logic [31:0] din,
                         output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = smp_tdo;
    oe_in_shift = smp_oe;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = smp_tdo;
    end
    oe_in_exit = smp_oe;
    step(1, 0); step(0, 0);
  endtask

  task automatic send_cmd(input string req, input logic [7:0] op,
                          input logic [7:0] exp_stb);
    logic [7:0] cap, s;
    ir_scan(op, cap, s);
    push_exp(req, 32'(exp_stb));
    observe(32'(s));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  cap, s;

    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    // R1: during reset
    push_exp("R1 oe in reset", 32'd0);         observe(32'(tdo_oe));
    push_exp("R1 strobes in reset", 32'd0);    observe(32'(stb));
    rst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);  // to Run-Test/Idle
    push_exp("R1 strobes after reset", 32'd0); observe(32'(smp_stb));
    push_exp("R8 oe in idle", 32'd0);          observe(32'(smp_oe));

    // R1/R3: identification is the default instruction
    dr_scan(32, 32'h0, rd);
    push_exp("R3 idcode default", IDC);        observe(rd);
    push_exp("R8 oe during shift", 32'd1);     observe(32'(oe_in_shift));
    push_exp("R8 oe in exit1", 32'd0);         observe(32'(oe_in_exit));

    // R9 capture pattern, R4 status read
    ir_scan(8'h41, cap, s);
    push_exp("R9 ir capture", 32'h01);         observe(32'(cap));
    push_exp("R5 status op no strobe", 32'd0); observe(32'(s));
    crc = 1'b1; tmo = 1'b1; done = 1'b1;
    dr_scan(32, 32'h0, rd);
    push_exp("R4 status crc/timeout/done", 32'h0000_2009); observe(rd);
    crc = 1'b0; tmo = 1'b0; done = 1'b0; idf = 1'b1;
    dr_scan(32, 32'h0, rd);
    push_exp("R4 status id fail", 32'h0000_0004); observe(rd);
    idf = 1'b0;

    // R6: gated before enable
    send_cmd("R6 xfer before enable", 8'h17, 8'h00);
    send_cmd("R6 erase before enable", 8'h05, 8'h00);

    // R5: each command strobes its own bit for one clock
    send_cmd("R5 enable", 8'h15, 8'h01);
    step(0, 0);
    push_exp("R5 strobe one clock", 32'd0);    observe(32'(smp_stb));
    send_cmd("R5 erase", 8'h05, 8'h08);
    send_cmd("R5 erase done", 8'h09, 8'h10);
    send_cmd("R5 addr init", 8'h12, 8'h20);
    send_cmd("R5 xfer", 8'h17, 8'h40);
    send_cmd("R5 noop", 8'h02, 8'h04);
    send_cmd("R5 reprogram", 8'h3C, 8'h80);
    send_cmd("R5 disable", 8'h3A, 8'h02);
    send_cmd("R6 xfer after disable", 8'h17, 8'h00);
    send_cmd("R6 erase after disable", 8'h05, 8'h00);

    // R7: unknown code -> bypass + bad flag
    send_cmd("R7 unknown no strobe", 8'h55, 8'h00);
    dr_scan(4, 32'h0000_000D, rd);
    push_exp("R7 bypass delay", 32'h0000_000A); observe(rd & 32'hF);
    ir_scan(8'h41, cap, s);
    crc = 1'b1;
    dr_scan(32, 32'h0, rd);
    push_exp("R7 bad flag with crc", 32'h0000_0003); observe(rd);
    crc = 1'b0;

    // R2: five tms-high clocks from Shift-DR reset the controller
    send_cmd("R6 enable again", 8'h15, 8'h01);
    ir_scan(8'h41, cap, s);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    dr_scan(32, 32'h0, rd);
    push_exp("R2 idcode after tms reset", IDC); observe(rd);
    send_cmd("R2 enable cleared by reset", 8'h17, 8'h00);

    // R7: flag is sticky across test reset
    ir_scan(8'h41, cap, s);
    dr_scan(32, 32'h0, rd);
    push_exp("R7 bad flag sticky", 32'h0000_0002); observe(rd);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule